// File: doc/BRIEF.md
# Instruction Word and Operand Field Decoder

This block takes the first 16-bit word of an instruction for a small 16-bit processor and classifies it. It does not access memory, read registers or execute anything. The low five bits hold the opcode of a basic instruction. A basic word carries two operand fields: a 6-bit source-side field in bits 15:10 (operand a) and a 5-bit destination-side field in bits 9:5 (operand b). When the low five bits are all zero, the word is a special instruction. Its opcode then sits in bits 9:5, and the only operand is the 6-bit field in bits 15:10.

For each operand the decoder reports the following:
- an addressing-mode class
- a register index
- whether the operand needs one extra instruction word, and where that word sits
- whether the operand can be written

The a field may also hold a short inline constant, which the decoder expands to 16 bits. From the two extra-word flags it derives the instruction length in words and the cycles spent on operand lookup. It also flags opcodes that have no assigned function. The outputs feed a separate fetch/execute sequencer.

A parameter chooses between a purely combinational path and a registered output stage. The registered stage loads under a clock enable and has an asynchronous active-low reset that is released synchronously. The default is the registered stage, with one cycle of latency.

Top module: `instr_decoder`

## Requirements
- R1: While reset is asserted, and after its release until the first load, every output is zero.
- R2: If bits 4:0 are nonzero, is_special is 0 and opcode equals bits 4:0. If bits 4:0 are zero, is_special is 1 and opcode equals bits 9:5.
- R3: Operand codes 0x00-0x07 give mode 0 (register), 0x08-0x0f give mode 1 (memory at register), and 0x10-0x17 give mode 2 (memory at register plus extra word). The register index is code[2:0] for codes below 0x18 and 0 otherwise.
- R4: Code 0x18 gives mode 3 (push, pre-decrement) in the b field and mode 4 (pop, post-increment) in the a field. Code 0x19 gives mode 5 (peek). Code 0x1a gives mode 6 (stack pointer plus extra word).
- R5: Code 0x1b gives mode 7 (SP), 0x1c gives mode 8 (PC), 0x1d gives mode 9 (EX), 0x1e gives mode 10 (memory at extra word) and 0x1f gives mode 11 (extra word as constant).
- R6: In the a field, codes 0x20-0x3f give mode 12 (inline constant). a_literal then equals (code - 0x21) mod 65536, a value from 0xffff up to 0x001e. For every other a code, a_literal is 0.
- R7: An operand is writable unless its mode is 11, 12 or 15.
- R8: The extra flag is set for codes 0x10-0x17, 0x1a, 0x1e and 0x1f. The a operand's extra word comes first. b_word_ofs is 0 when b needs no extra word, and otherwise equals 1 + a_extra.
- R9: lookup_cycles = a_extra + b_extra, and instr_len = 1 + a_extra + b_extra.
- R10: For a special word the b operand reports mode 15 (none), register 0, no extra word and not writable.
- R11: illegal is 1 for the basic opcodes 0x18, 0x19, 0x1c and 0x1d. It is also 1 for every special opcode other than 0x01, 0x08-0x0c and 0x10-0x12. Otherwise it is 0.
- R12: With the registered stage, the outputs reflect instr_word one clock after an edge at which load_en is 1. They hold their value across edges at which load_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Clock enable of the output stage |
| instr_word | input | 16 | First word of the instruction |
| is_special | output | 1 | Word is a special (single-operand) instruction |
| opcode | output | 5 | Basic or special opcode |
| illegal | output | 1 | Opcode has no assigned function |
| a_mode | output | 4 | Mode class of operand a |
| a_reg | output | 3 | Register index of operand a |
| a_extra | output | 1 | Operand a needs an extra word |
| a_writable | output | 1 | Operand a may be written |
| a_literal | output | 16 | Expanded inline constant of operand a |
| b_mode | output | 4 | Mode class of operand b |
| b_reg | output | 3 | Register index of operand b |
| b_extra | output | 1 | Operand b needs an extra word |
| b_writable | output | 1 | Operand b may be written |
| b_word_ofs | output | 2 | Word offset of b's extra word |
| instr_len | output | 2 | Instruction length in words |
| lookup_cycles | output | 2 | Operand lookup cycle cost |

## Verification
The block holds no state apart from its output register, so a wrong value in that register appears at the ports on the very next clock. A wrong load or hold shows up as a stale or premature field in the cycle after the enable edge. The bench runs every one of the 65536 words through a behavioural reference and compares all outputs in each cycle. Any decode error therefore shows on the first word that exercises it. A burst with the enable toggling shows up a register that loads when it should hold.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int WORD_W  = 16;
  localparam int OPC_W   = 5;
  localparam int FLDB_W  = 5;
  localparam int FLDA_W  = 6;
  localparam int RIDX_W  = 3;
  localparam int MODE_W  = 4;
  localparam int CNT_W   = 2;

  typedef enum logic [MODE_W-1:0] {
    MD_REG  = 4'd0,
    MD_RIND = 4'd1,
    MD_ROFS = 4'd2,
    MD_PUSH = 4'd3,
    MD_POP  = 4'd4,
    MD_PEEK = 4'd5,
    MD_PICK = 4'd6,
    MD_SP   = 4'd7,
    MD_PC   = 4'd8,
    MD_EX   = 4'd9,
    MD_MABS = 4'd10,
    MD_LITW = 4'd11,
    MD_LITI = 4'd12,
    MD_NONE = 4'd15
  } opnd_mode_e;

  typedef struct packed {
    opnd_mode_e          mode;
    logic [RIDX_W-1:0]   ridx;
    logic                extra;
    logic                wr;
  } opnd_t;

  typedef struct packed {
    logic                spec;
    logic [OPC_W-1:0]    opc;
    logic                illegal;
    opnd_t               a;
    logic [WORD_W-1:0]   lit;
    opnd_t               b;
    logic [CNT_W-1:0]    bofs;
    logic [CNT_W-1:0]    len;
    logic [CNT_W-1:0]    cyc;
  } dec_t;
endpackage

// File: rtl/opnd_field_dec.sv
module opnd_field_dec
  import idec_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter bit IS_B   = 1'b0
) (
  input  logic [CODE_W-1:0] code,
  input  logic              active,
  output opnd_t             info
);
  localparam int EXT_W = 8;
  localparam logic [EXT_W-1:0] SHORT_BASE = 8'h20;
  localparam logic [EXT_W-1:0] LITW_CODE  = 8'h1f;
  localparam logic [EXT_W-1:0] STACK_BASE = 8'h18;

  logic [EXT_W-1:0] ext;
  assign ext = {{(EXT_W-CODE_W){1'b0}}, code};

  always_comb begin
    info.mode  = MD_NONE;
    info.ridx  = '0;
    info.extra = 1'b0;
    info.wr    = 1'b0;
    if (active) begin
      info.wr = (ext < LITW_CODE);
      if (ext < STACK_BASE) info.ridx = ext[RIDX_W-1:0];
      if (ext >= SHORT_BASE) begin
        info.mode = MD_LITI;
      end else begin
        case (ext[4:3])
          2'd0: info.mode = MD_REG;
          2'd1: info.mode = MD_RIND;
          2'd2: begin info.mode = MD_ROFS; info.extra = 1'b1; end
          default: begin
            case (ext[2:0])
              3'd0: info.mode = IS_B ? MD_PUSH : MD_POP;
              3'd1: info.mode = MD_PEEK;
              3'd2: begin info.mode = MD_PICK; info.extra = 1'b1; end
              3'd3: info.mode = MD_SP;
              3'd4: info.mode = MD_PC;
              3'd5: info.mode = MD_EX;
              3'd6: begin info.mode = MD_MABS; info.extra = 1'b1; end
              default: begin info.mode = MD_LITW; info.extra = 1'b1; end
            endcase
          end
        endcase
      end
    end
  end

  // R7: a constant-valued operand must never be reported writable
  always_comb begin
    if (info.mode == MD_LITW || info.mode == MD_LITI)
      a_r7_const_readonly: assert (!info.wr);
  end
endmodule

// File: rtl/op_class.sv
module op_class
  import idec_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              spec,
  output logic [OPC_W-1:0]  opc,
  output logic              illegal
);
  logic [OPC_W-1:0] low_f, mid_f;
  assign low_f = word[OPC_W-1:0];
  assign mid_f = word[OPC_W+FLDB_W-1:OPC_W];

  always_comb begin
    spec    = (low_f == '0);
    opc     = spec ? mid_f : low_f;
    illegal = 1'b0;
    if (spec) begin
      case (mid_f)
        5'h01, 5'h08, 5'h09, 5'h0a, 5'h0b, 5'h0c,
        5'h10, 5'h11, 5'h12: illegal = 1'b0;
        default:             illegal = 1'b1;
      endcase
    end else begin
      case (low_f)
        5'h18, 5'h19, 5'h1c, 5'h1d: illegal = 1'b1;
        default:                    illegal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/len_calc.sv
module len_calc
  import idec_pkg::*;
(
  input  logic             a_x,
  input  logic             b_x,
  output logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] cyc,
  output logic [CNT_W-1:0] bofs
);
  always_comb begin
    cyc  = CNT_W'(a_x) + CNT_W'(b_x);
    len  = cyc + CNT_W'(1);
    bofs = b_x ? (CNT_W'(1) + CNT_W'(a_x)) : '0;
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import idec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [15:0]       instr_word,
  output logic              is_special,
  output logic [4:0]        opcode,
  output logic              illegal,
  output logic [3:0]        a_mode,
  output logic [2:0]        a_reg,
  output logic              a_extra,
  output logic              a_writable,
  output logic [15:0]       a_literal,
  output logic [3:0]        b_mode,
  output logic [2:0]        b_reg,
  output logic              b_extra,
  output logic              b_writable,
  output logic [1:0]        b_word_ofs,
  output logic [1:0]        instr_len,
  output logic [1:0]        lookup_cycles
);
  localparam int A_LSB = OPC_W + FLDB_W;
  localparam int B_LSB = OPC_W;
  localparam logic [WORD_W-1:0] LIT_BIAS = WORD_W'(33);

  dec_t d;
  dec_t q;

  op_class u_cls (
    .word    (instr_word),
    .spec    (d.spec),
    .opc     (d.opc),
    .illegal (d.illegal)
  );

  opnd_field_dec #(.CODE_W(FLDA_W), .IS_B(1'b0)) u_fa (
    .code   (instr_word[A_LSB+FLDA_W-1:A_LSB]),
    .active (1'b1),
    .info   (d.a)
  );

  opnd_field_dec #(.CODE_W(FLDB_W), .IS_B(1'b1)) u_fb (
    .code   (instr_word[B_LSB+FLDB_W-1:B_LSB]),
    .active (!d.spec),
    .info   (d.b)
  );

  assign d.lit = (d.a.mode == MD_LITI)
               ? ({{(WORD_W-FLDA_W){1'b0}}, instr_word[A_LSB+FLDA_W-1:A_LSB]} - LIT_BIAS)
               : '0;

  len_calc u_len (
    .a_x  (d.a.extra),
    .b_x  (d.b.extra),
    .len  (d.len),
    .cyc  (d.cyc),
    .bofs (d.bofs)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [1:0] rsync;
      logic       srst_n;
      dec_t       q_nxt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync <= 2'b00;
        else        rsync <= {rsync[0], 1'b1};
      end
      assign srst_n = rsync[1];

      always_comb begin
        q_nxt = q;
        if (load_en) q_nxt = d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (!srst_n) q <= '0;
        else              q <= q_nxt;
      end

      // R12: a stage that is not enabled keeps every field
      a_r12_hold: assert property (@(posedge clk) disable iff (!srst_n)
        !load_en |=> $stable(q));
      // R10: special words carry no b operand
      a_r10_spec_no_b: assert property (@(posedge clk) disable iff (!srst_n)
        q.spec |-> (q.b.mode == MD_NONE && !q.b.extra && !q.b.wr));
      // R6: expanded inline constants lie in -1..30
      a_r6_lit_range: assert property (@(posedge clk) disable iff (!srst_n)
        (q.a.mode == MD_LITI) |-> (q.lit == 16'hffff || q.lit <= 16'd30));
      // R11: special opcode zero is never a valid instruction
      a_r11_spec_zero: assert property (@(posedge clk) disable iff (!srst_n)
        (q.spec && q.opc == '0) |-> q.illegal);
      // R9: length and cost stay one word apart
      a_r9_len_cost: assert property (@(posedge clk) disable iff (!srst_n)
        (q.len != '0) |-> (q.len == q.cyc + 2'd1));
    end else begin : g_comb
      assign q = d;
    end
  endgenerate

  assign is_special    = q.spec;
  assign opcode        = q.opc;
  assign illegal       = q.illegal;
  assign a_mode        = q.a.mode;
  assign a_reg         = q.a.ridx;
  assign a_extra       = q.a.extra;
  assign a_writable    = q.a.wr;
  assign a_literal     = q.lit;
  assign b_mode        = q.b.mode;
  assign b_reg         = q.b.ridx;
  assign b_extra       = q.b.extra;
  assign b_writable    = q.b.wr;
  assign b_word_ofs    = q.bofs;
  assign instr_len     = q.len;
  assign lookup_cycles = q.cyc;
endmodule

// File: tb/instr_decoder_bench.sv
`timescale 1ns/1ps
module instr_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_en;
  logic [15:0] instr_word;
  logic        is_special, illegal, a_extra, a_writable, b_extra, b_writable;
  logic [4:0]  opcode;
  logic [3:0]  a_mode, b_mode;
  logic [2:0]  a_reg, b_reg;
  logic [15:0] a_literal;
  logic [1:0]  b_word_ofs, instr_len, lookup_cycles;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  int e_spec, e_opc, e_ill, e_len, e_cyc, e_bofs;
  int e_am, e_ar, e_ax, e_aw, e_alit;
  int e_bm, e_br, e_bx, e_bw;

  always #2 clk = ~clk;

  instr_decoder u_instr_decoder (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .instr_word(instr_word),
    .is_special(is_special), .opcode(opcode), .illegal(illegal),
    .a_mode(a_mode), .a_reg(a_reg), .a_extra(a_extra), .a_writable(a_writable),
    .a_literal(a_literal), .b_mode(b_mode), .b_reg(b_reg), .b_extra(b_extra),
    .b_writable(b_writable), .b_word_ofs(b_word_ofs), .instr_len(instr_len),
    .lookup_cycles(lookup_cycles)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d (word %h)", tag, what, act, exp, instr_word);
    end
  endtask

  function automatic string mode_tag(input int c);
    if (c < 24) return "R3";
    if (c < 27) return "R4";
    if (c < 32) return "R5";
    return "R6";
  endfunction

  task automatic field(input int c, input bit isb, output int m, output int r,
                       output int x, output int w, output int lit);
    if (c < 8)        m = 0;
    else if (c < 16)  m = 1;
    else if (c < 24)  m = 2;
    else if (c == 24) m = isb ? 3 : 4;
    else if (c < 32)  m = c - 20;
    else              m = 12;
    r   = (c < 24) ? (c % 8) : 0;
    x   = ((c >= 16 && c < 24) || c == 26 || c == 30 || c == 31) ? 1 : 0;
    w   = (c < 31) ? 1 : 0;
    lit = (c >= 32) ? ((c - 33) & 16'hffff) : 0;
  endtask

  task automatic model(input logic [15:0] w);
    int low, mid, ac, dummy;
    low = int'(w[4:0]);
    mid = int'(w[9:5]);
    ac  = int'(w[15:10]);
    e_spec = (low == 0) ? 1 : 0;
    e_opc  = e_spec ? mid : low;
    if (e_spec) e_ill = (mid == 1 || (mid >= 8 && mid <= 12) || (mid >= 16 && mid <= 18)) ? 0 : 1;
    else        e_ill = (low == 24 || low == 25 || low == 28 || low == 29) ? 1 : 0;
    field(ac, 1'b0, e_am, e_ar, e_ax, e_aw, e_alit);
    if (e_spec) begin
      e_bm = 15; e_br = 0; e_bx = 0; e_bw = 0;
    end else begin
      field(mid, 1'b1, e_bm, e_br, e_bx, e_bw, dummy);
    end
    e_cyc  = e_ax + e_bx;
    e_len  = 1 + e_cyc;
    e_bofs = e_bx ? 1 + e_ax : 0;
  endtask

  task automatic compare_all();
    chk("R2",  "is_special", int'(is_special), e_spec);
    chk("R2",  "opcode", int'(opcode), e_opc);
    chk("R11", "illegal", int'(illegal), e_ill);
    chk(mode_tag(int'(instr_word[15:10])), "a_mode", int'(a_mode), e_am);
    chk("R3",  "a_reg", int'(a_reg), e_ar);
    chk("R8",  "a_extra", int'(a_extra), e_ax);
    chk("R7",  "a_writable", int'(a_writable), e_aw);
    chk("R6",  "a_literal", int'(a_literal), e_alit);
    chk(e_spec ? "R10" : mode_tag(int'(instr_word[9:5])), "b_mode", int'(b_mode), e_bm);
    chk(e_spec ? "R10" : "R3", "b_reg", int'(b_reg), e_br);
    chk("R8",  "b_extra", int'(b_extra), e_bx);
    chk("R7",  "b_writable", int'(b_writable), e_bw);
    chk("R8",  "b_word_ofs", int'(b_word_ofs), e_bofs);
    chk("R9",  "instr_len", int'(instr_len), e_len);
    chk("R9",  "lookup_cycles", int'(lookup_cycles), e_cyc);
  endtask

  // inputs applied at a falling edge, result sampled one full cycle later
  task automatic drive(input logic [15:0] w, input bit en);
    logic [15:0] held;
    held = instr_word;
    instr_word = w;
    load_en    = en;
    @(posedge clk);
    @(negedge clk);
    if (en) model(w);
    else    instr_word = held; // R12: keep message context of the loaded word
    compare_all();
    if (!en) chk("R12", "held opcode", int'(opcode), e_opc);
    instr_word = w;
  endtask

  initial begin
    rst_n = 1'b0; load_en = 1'b1; instr_word = 16'h7c21;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", int'(|{is_special, opcode, illegal, a_mode, a_reg, a_extra,
        a_writable, a_literal, b_mode, b_reg, b_extra, b_writable, b_word_ofs, instr_len,
        lookup_cycles}), 0);
    load_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "outputs before first load", int'(|{is_special, opcode, illegal, a_mode, a_reg,
        a_extra, a_writable, a_literal, b_mode, b_reg, b_extra, b_writable, b_word_ofs,
        instr_len, lookup_cycles}), 0);
    // exhaustive sweep with the stage enabled every cycle
    for (int i = 0; i < 65536; i++) drive(16'(i), 1'b1);
    // corner words: push/pop, inline extremes, three-word instruction
    drive(16'h0301, 1'b1);  // R4 push destination, register source
    drive(16'h6301, 1'b1);  // R4 pop source into push destination
    drive(16'h8001, 1'b1);  // R6 inline -1
    drive(16'hfc01, 1'b1);  // R6 inline 30
    drive(16'h7e21, 1'b1);  // R8 R9 both operands carry extra words
    drive(16'hfc00, 1'b1);  // R11 special opcode zero
    // enable toggling burst
    begin
      logic [15:0] lf = 16'hace1;
      for (int k = 0; k < 96; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        drive(lf, (k % 3) != 0);
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog run did not complete actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule